// File: doc/BRIEF.md
# Pixel Time-over-Threshold and Arrival Counter

This block is the digital half of one pixel in a hybrid detector. It watches a single binary input from the pixel's discriminator and, during a short acquisition window, records two figures. The first is the length of time the discriminator stays high. The second is the time from the first hit up to the point where the window closes. Both figures are kept in short saturating LFSR counters. The counters advance on ticks of an acquisition clock that is divided from the block clock. The counters are only enabled while the window is open, so the logic stays idle between windows.

A sticky hit flag marks any pixel in which a counter has started. This flag feeds the zero-suppression logic downstream. A readout strobe, given after the window closes, freezes a copy of the flag and loads both counter values into a shift register. A pixel with no hit is bypassed on the serial chain, so a column of pixels can be read sparsely. Three configuration inputs control the pixel. One silences it. One lets an injected test pulse stand in for a real hit. One switches the pixel into a calibration mode where it counts discriminator edges instead of measuring time.

Top module: `pixel_tot_toa`

## Requirements
- R1: After reset, hitFlag and flagHeld are 0, both counters hold the seed state (all ones), and shiftOut follows shiftIn.
- R2: A window opens on the cycle in which shutter is first seen high. That opening cycle clears both counters to the seed and clears hitFlag. Counting begins on the following cycle. Ticks fall on every CLK_DIV-th cycle after the opening cycle (default 2). In timing mode, the ToT counter advances once on every tick at which the effective hit input is high.
- R3: In timing mode, the ToA counter starts on the first rising edge of the hit input that is seen after the opening cycle. It then advances on every tick up to the close of the window, including a tick that falls in the same cycle as the rising edge. An input that is already high at the opening cycle does not start the ToA counter.
- R4: Each counter steps as next = {s[W-2:0], s[W-1]^s[W-2]}, starting from the all-ones seed. It stops at the state reached after 2^W-2 steps (14 steps for W=4) and holds there. It never takes the all-zero state.
- R5: hitFlag becomes 1 on the cycle in which either counter starts, or on any counted event in calibration mode. It stays at 1 until the next window opens.
- R6: While cfgMask is 1, no counter advances and hitFlag stays at 0.
- R7: With cfgTestEn at 1, testPulse acts as a hit in the same way as disc. With cfgTestEn at 0, testPulse has no effect.
- R8: With cfgCountMode at 1, the ToA counter advances once for each rising edge of the hit input inside the window, and the ToT counter stays at the seed.
- R9: readLatch with shutter low copies hitFlag into flagHeld and loads the shift register with {ToT, ToA}. The ToT counter's MSB appears first on shiftOut, and each shiftEn cycle brings the next bit forward.
- R10: While flagHeld is 0, shiftOut equals shiftIn (the pixel is bypassed).
- R11: While shutter is low, disc and testPulse change neither the counters nor hitFlag.
- R12: readLatch while shutter is high is ignored, and flagHeld does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shutter | input | 1 | Acquisition window, high while open |
| disc | input | 1 | Discriminator output |
| testPulse | input | 1 | Injected test hit |
| cfgMask | input | 1 | Silences the pixel |
| cfgTestEn | input | 1 | Lets testPulse act as a hit |
| cfgCountMode | input | 1 | Calibration event-counting mode |
| readLatch | input | 1 | Snapshot flag and counters for readout |
| shiftEn | input | 1 | Shift the readout register one bit |
| shiftIn | input | 1 | Serial chain input from the previous pixel |
| shiftOut | output | 1 | Serial chain output |
| hitFlag | output | 1 | Live sticky hit flag |
| flagHeld | output | 1 | Flag copy frozen at readout |

## Verification
Two things can fall in the same cycle: the first rising edge that starts the arrival counter, and either the close of the window or an acquisition tick. The bench places rising edges on the last open cycle, on a cycle without a tick, and on a cycle with a tick. In each case it checks that the flag is set. It also checks that the ToA counter shows zero steps when the edge has no tick, and one step when the edge coincides with the last tick. A rising edge in the first cycle after the window closes must leave the counters and the flag untouched.

// File: rtl/pix_pkg.sv
package pix_pkg;

  typedef struct packed {
    logic clear;
    logic totStep;
    logic toaStep;
    logic flagSet;
    logic snap;
    logic shift;
  } pix_strobe_t;

endpackage

// File: rtl/pix_lfsr_sat.sv
module pix_lfsr_sat #(
  parameter int unsigned W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] state
);

  localparam logic [W-1:0] SEED = '1;

  function automatic logic [W-1:0] nextState(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [W-1:0] termState();
    logic [W-1:0] s;
    s = SEED;
    for (int i = 0; i < (2 ** W) - 2; i++) s = nextState(s);
    return s;
  endfunction

  localparam logic [W-1:0] TERM = termState();

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     state <= SEED;
    else if (clear)                state <= SEED;
    else if (step && state != TERM) state <= nextState(state);
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

  // R4
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == TERM && !clear) |=> state == TERM);

endmodule

// File: rtl/pix_ctrl.sv
module pix_ctrl
  import pix_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        shutter,
  input  logic        disc,
  input  logic        testPulse,
  input  logic        cfgMask,
  input  logic        cfgTestEn,
  input  logic        cfgCountMode,
  input  logic        readLatch,
  input  logic        shiftEn,
  output pix_strobe_t strb
);

  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          shutterQ;
  logic          hitQ;
  logic          toaRun;
  logic [DW-1:0] divCnt;
  logic          hitIn;
  logic          openNow;
  logic          active;
  logic          tick;
  logic          rise;

  assign hitIn   = !cfgMask && (disc || (cfgTestEn && testPulse));
  assign openNow = shutter && !shutterQ;
  assign active  = shutter && shutterQ;
  assign tick    = active && (divCnt == DIV_LAST);
  assign rise    = hitIn && !hitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutterQ <= 1'b0;
      hitQ     <= 1'b0;
      divCnt   <= '0;
      toaRun   <= 1'b0;
    end else begin
      shutterQ <= shutter;
      hitQ     <= hitIn;
      if (!active || tick) divCnt <= '0;
      else                 divCnt <= divCnt + 1'b1;
      if (openNow)                                  toaRun <= 1'b0;
      else if (active && rise && !cfgCountMode)     toaRun <= 1'b1;
    end
  end

  always_comb begin
    strb.clear   = openNow;
    strb.snap    = readLatch && !shutter;
    strb.shift   = shiftEn && !shutter && !strb.snap;
    if (cfgCountMode) begin
      strb.totStep = 1'b0;
      strb.toaStep = active && rise;
      strb.flagSet = active && rise;
    end else begin
      strb.totStep = tick && hitIn;
      strb.toaStep = tick && (toaRun || rise);
      strb.flagSet = active && (rise || (tick && hitIn));
    end
  end

  // R11
  idle_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shutter |-> !(strb.totStep || strb.toaStep || strb.flagSet));

  // R8
  count_mode_tot_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgCountMode |-> !strb.totStep);

endmodule

// File: rtl/pix_datapath.sv
module pix_datapath
  import pix_pkg::*;
#(
  parameter int unsigned  CNT_W = 4,
  parameter logic [CNT_W-1:0] TAPS = 4'b1100
) (
  input  logic        clk,
  input  logic        rstN,
  input  pix_strobe_t strb,
  input  logic        shiftIn,
  output logic        shiftOut,
  output logic        hitFlag,
  output logic        flagHeld
);

  localparam int unsigned SR_W = 2 * CNT_W;

  logic [CNT_W-1:0] totState;
  logic [CNT_W-1:0] toaState;
  logic [SR_W-1:0]  shReg;

  pix_lfsr_sat #(.W(CNT_W), .TAPS(TAPS)) u_tot (
    .clk(clk), .rstN(rstN), .clear(strb.clear), .step(strb.totStep), .state(totState)
  );

  pix_lfsr_sat #(.W(CNT_W), .TAPS(TAPS)) u_toa (
    .clk(clk), .rstN(rstN), .clear(strb.clear), .step(strb.toaStep), .state(toaState)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitFlag  <= 1'b0;
      flagHeld <= 1'b0;
      shReg    <= '1;
    end else begin
      if (strb.clear)        hitFlag <= 1'b0;
      else if (strb.flagSet) hitFlag <= 1'b1;
      if (strb.snap) begin
        flagHeld <= hitFlag;
        shReg    <= {totState, toaState};
      end else if (strb.shift && flagHeld) begin
        shReg    <= {shReg[SR_W-2:0], shiftIn};
      end
    end
  end

  assign shiftOut = flagHeld ? shReg[SR_W-1] : shiftIn;

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitFlag && !strb.clear) |=> hitFlag);

endmodule

// File: rtl/pixel_tot_toa.sv
module pixel_tot_toa
  import pix_pkg::*;
#(
  parameter int unsigned      CNT_W   = 4,
  parameter logic [CNT_W-1:0] TAPS    = 4'b1100,
  parameter int unsigned      CLK_DIV = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic shutter,
  input  logic disc,
  input  logic testPulse,
  input  logic cfgMask,
  input  logic cfgTestEn,
  input  logic cfgCountMode,
  input  logic readLatch,
  input  logic shiftEn,
  input  logic shiftIn,
  output logic shiftOut,
  output logic hitFlag,
  output logic flagHeld
);

  pix_strobe_t strb;

  pix_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .shutter(shutter), .disc(disc), .testPulse(testPulse),
    .cfgMask(cfgMask), .cfgTestEn(cfgTestEn), .cfgCountMode(cfgCountMode),
    .readLatch(readLatch), .shiftEn(shiftEn), .strb(strb)
  );

  pix_datapath #(.CNT_W(CNT_W), .TAPS(TAPS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .hitFlag(hitFlag), .flagHeld(flagHeld)
  );

  // R6
  mask_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMask && !hitFlag) |=> !hitFlag);

  // R12
  held_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutter |=> $stable(flagHeld));

endmodule

// File: tb/pixel_tot_toa_bench.sv
module pixel_tot_toa_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int SATN = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shutter = 0, disc = 0, testPulse = 0;
  logic cfgMask = 0, cfgTestEn = 0, cfgCountMode = 0;
  logic readLatch = 0, shiftEn = 0, shiftIn = 0;
  logic shiftOut, hitFlag, flagHeld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_tot_toa #(.CLK_DIV(DIV)) u_pixel_tot_toa (
    .clk(clk), .rstN(rstN), .shutter(shutter), .disc(disc), .testPulse(testPulse),
    .cfgMask(cfgMask), .cfgTestEn(cfgTestEn), .cfgCountMode(cfgCountMode),
    .readLatch(readLatch), .shiftEn(shiftEn), .shiftIn(shiftIn),
    .shiftOut(shiftOut), .hitFlag(hitFlag), .flagHeld(flagHeld)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lfsrAfter(input int n);
    logic [3:0] s = 4'hF;
    int k = (n > SATN) ? SATN : n;
    for (int i = 0; i < k; i++) s = {s[2:0], s[3] ^ s[2]};
    return s;
  endfunction

  // drives one window; cycle 0 is the opening cycle; model follows R2, R3, R5-R8
  task automatic runWindow(input int len, input logic [63:0] pat, input bit viaTp,
                           output int totN, output int toaN, output bit flg);
    bit prev = 0, run = 0;
    totN = 0; toaN = 0; flg = 0;
    for (int i = 0; i < len; i++) begin
      bit hi, rise, act, tick;
      @(negedge clk);
      shutter = 1'b1;
      if (viaTp) testPulse = pat[i]; else disc = pat[i];
      hi   = !cfgMask && (viaTp ? (cfgTestEn && pat[i]) : pat[i]);
      rise = hi && !prev;
      act  = (i >= 1);
      tick = act && (i % DIV == 0);
      if (cfgCountMode) begin
        if (act && rise) begin toaN++; flg = 1; end
      end else begin
        if (act && rise) begin run = 1; flg = 1; end
        if (tick && hi) begin totN++; flg = 1; end
        if (tick && run) toaN++;
      end
      prev = hi;
    end
    @(negedge clk);
    shutter = 0; disc = 0; testPulse = 0;
  endtask

  task automatic readCheck(input string tag, input bit expFlag, input int totN, input int toaN);
    logic [7:0] expWord, got;
    @(negedge clk);
    check({tag, " live flag (R5)"}, hitFlag, expFlag);
    readLatch = 1;
    @(negedge clk);
    readLatch = 0;
    check({tag, " held flag (R9)"}, flagHeld, expFlag);
    if (expFlag) begin
      expWord = {lfsrAfter(totN), lfsrAfter(toaN)};
      for (int b = 7; b >= 0; b--) begin
        got[b] = shiftOut;
        shiftEn = 1;
        @(negedge clk);
      end
      shiftEn = 0;
      check({tag, " shifted word (R9)"}, got, expWord);
    end else begin
      shiftIn = 1; #1;
      check({tag, " bypass high (R10)"}, shiftOut, 1);
      shiftIn = 0; #1;
      check({tag, " bypass low (R10)"}, shiftOut, 0);
    end
  endtask

  task automatic testReset();
    check("reset hitFlag (R1)", hitFlag, 0);
    check("reset flagHeld (R1)", flagHeld, 0);
    shiftIn = 1; #1;
    check("reset bypass (R1)", shiftOut, 1);
    shiftIn = 0;
  endtask

  task automatic testTot();
    int t, a; bit f;
    runWindow(20, 64'h1F8, 0, t, a, f);   // disc high cycles 3..8
    check("tot model (R2)", t, 3);
    check("toa model (R3)", a, 8);
    readCheck("pulse R2 R3", f, t, a);
  endtask

  task automatic testHighAtOpen();
    int t, a; bit f;
    runWindow(12, 64'h1F, 0, t, a, f);    // high from opening cycle
    check("open-high toa (R3)", a, 0);
    readCheck("open-high R3", f, t, a);
  endtask

  task automatic testSaturate();
    int t, a; bit f;
    runWindow(60, {4'h0, {59{1'b1}}, 1'b0}, 0, t, a, f);
    check("sat count above limit (R4)", t, 29);
    readCheck("saturate R4", f, t, a);
  endtask

  task automatic testEdgeCases();
    int t, a; bit f;
    runWindow(10, 64'h200, 0, t, a, f);   // rise on last open cycle, no tick
    readCheck("last-cycle rise R3 R5", f, t, a);
    runWindow(10, 64'h300, 0, t, a, f);   // rise on last tick
    check("tick rise toa (R3)", a, 1);
    readCheck("tick rise R3", f, t, a);
  endtask

  task automatic testMask();
    int t, a; bit f;
    cfgMask = 1;
    runWindow(20, 64'h0F0F0, 0, t, a, f);
    cfgMask = 0;
    readCheck("mask R6", 0, 0, 0);
  endtask

  task automatic testPulseEn();
    int t, a; bit f;
    cfgTestEn = 1;
    runWindow(16, 64'h0FC, 1, t, a, f);
    readCheck("test pulse on R7", f, t, a);
    cfgTestEn = 0;
    runWindow(16, 64'h0FC, 1, t, a, f);
    readCheck("test pulse off R7", 0, 0, 0);
  endtask

  task automatic testCountMode();
    int t, a; bit f;
    cfgCountMode = 1;
    runWindow(24, 64'h0A54A, 0, t, a, f);  // several separate pulses
    cfgCountMode = 0;
    check("count mode events (R8)", a, 7);
    readCheck("count mode R8", f, 0, a);
  endtask

  task automatic testOutsideWindow();
    int t, a; bit f;
    runWindow(12, 64'h0C, 0, t, a, f);
    @(negedge clk); disc = 1;             // right after close
    @(negedge clk); disc = 0;
    @(negedge clk); testPulse = 1; cfgTestEn = 1;
    @(negedge clk); testPulse = 0; cfgTestEn = 0; disc = 1;
    @(negedge clk); disc = 0;
    readCheck("outside window R11", f, t, a);
  endtask

  task automatic testLatchInWindow();
    int t, a; bit f;
    runWindow(8, 64'h04, 0, t, a, f);
    readCheck("prime R9", f, t, a);         // flagHeld now 1
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); shutter = 1; readLatch = (i == 3);
    end
    @(negedge clk); shutter = 0; readLatch = 0;
    check("latch in window ignored (R12)", flagHeld, 1);
    readCheck("cleared by open R2 R5", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testTot();
    testHighAtOpen();
    testSaturate();
    testEdgeCases();
    testMask();
    testPulseEn();
    testCountMode();
    testOutsideWindow();
    testLatchInWindow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule